// File: doc/BRIEF.md
# TDM Serial Channel Port

This block connects a system to a 2.048 Mbit/s time-division-multiplexed serial bus. Each 125 µs frame on the bus carries 32 timeslots of eight bits. On the receive side the port shifts in the serial stream, counts bits and timeslots, and hands each finished payload byte to the system with its line channel number and a one-clock strobe. On the transmit side it asks the system for the byte of each upcoming payload timeslot and shifts it out serially. In the timeslots that carry no payload it drives a fixed idle byte, so the output line is never left undriven.

A frame-sync input marks the start of a frame and realigns both directions at once. Received bits are sampled on the falling edge of the bit clock. Transmitted bits change on the rising edge. Which 24 of the 32 timeslots carry line channels is fixed at elaboration by a slot mask. Payload timeslots are numbered as line channels in ascending timeslot order.

Top module: `tdm_slot_port`

## Requirements
- R1: While rst_n is low, ser_out is 1, rx_valid and tx_req are 0, and slot_num is SLOTS-1.
- R2: A falling clock edge that samples frame_sync high also samples the most significant bit of timeslot 0. From that edge on, slot_num reads 0.
- R3: Received bits are sampled on falling edges, most significant bit first. The byte of timeslot s is made of the bits sampled at falling edges 8s to 8s+7 counted from the frame-sync edge.
- R4: The falling edge that samples the eighth bit of a payload timeslot raises rx_valid for exactly one clock, with that byte on rx_data and its channel on rx_chan.
- R5: Timeslots whose bit in PAYLOAD_MAP is 0 never raise rx_valid. Their received bits are discarded.
- R6: Line channels 0 to NCHAN-1 are the payload timeslots in ascending order. The default map clears the bit of every timeslot whose index mod 4 is 3 (3, 7, 11, 15, 19, 23, 27, 31), which leaves 24 channels.
- R7: Transmitted bit k of the frame (bit 7-(k mod 8) of timeslot k/8) is launched by the rising edge that follows falling edge k. It is held until the next rising edge.
- R8: tx_req pulses for one clock after the rising edge that launches the last bit of the previous timeslot, when the next timeslot is payload. tx_req_chan gives that timeslot's channel. tx_byte is captured at the following rising edge.
- R9: Timeslots that are not payload transmit IDLE_BYTE (default 8'hFF), whatever tx_byte holds.
- R10: Without frame_sync, the counters run freely. Timeslot SLOTS-1 is followed by timeslot 0, and both directions keep their alignment across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | High during the bit period of timeslot 0's first bit |
| ser_in | input | 1 | Serial receive data |
| rx_valid | output | 1 | One-clock strobe for a completed payload byte |
| rx_data | output | 8 | Received payload byte |
| rx_chan | output | $clog2(NCHAN) | Line channel of rx_data |
| slot_num | output | $clog2(SLOTS) | Timeslot of the most recently sampled bit |
| tx_byte | input | 8 | Byte for the requested transmit channel |
| tx_req | output | 1 | One-clock request for the next payload byte |
| tx_req_chan | output | $clog2(NCHAN) | Channel whose byte is requested |
| ser_out | output | 1 | Serial transmit data |

## Verification
The bench keeps the default 32-slot map, with its 24 channels and every fourth slot idle. It sets IDLE_BYTE to 8'h5A, so idle timeslots can be told apart from all-ones payload and from a line that is merely held high. Every bit of several full frames is compared in both directions. This covers a wrap from slot 31 to slot 0 without frame_sync and a frame_sync that arrives in the middle of a frame. The received and transmitted bytes follow per-frame seeds, so a shifted bit, channel or slot shows up at once.

// File: rtl/tdm_slot_port.sv
module tdm_slot_port #(
  parameter int SLOTS = 32,
  parameter logic [SLOTS-1:0] PAYLOAD_MAP = {(SLOTS/4){4'b0111}},
  parameter logic [7:0] IDLE_BYTE = 8'hFF
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             frame_sync,
  input  logic                             ser_in,
  output logic                             rx_valid,
  output logic [7:0]                       rx_data,
  output logic [$clog2(PAYLOAD_CNT)-1:0]   rx_chan,
  output logic [$clog2(SLOTS)-1:0]         slot_num,
  input  logic [7:0]                       tx_byte,
  output logic                             tx_req,
  output logic [$clog2(PAYLOAD_CNT)-1:0]   tx_req_chan,
  output logic                             ser_out
);

  function automatic int count_map();
    int n = 0;
    for (int i = 0; i < SLOTS; i++) if (PAYLOAD_MAP[i]) n++;
    return n;
  endfunction

  localparam int PAYLOAD_CNT = count_map();
  localparam int SW = $clog2(SLOTS);
  localparam int CW = $clog2(PAYLOAD_CNT);
  localparam int PW = SW + 3;

  function automatic logic [CW-1:0] chan_of(input logic [SW-1:0] s);
    int n = 0;
    for (int i = 0; i < SLOTS; i++) if (i < int'(s) && PAYLOAD_MAP[i]) n++;
    return CW'(n);
  endfunction

  // receive side: falling edge
  logic [PW-1:0] pos, pos_nxt;
  logic [7:0]    rx_sh;

  assign pos_nxt = frame_sync ? '0 : pos + 1'b1;

  wire [SW-1:0] rx_slot = pos_nxt[PW-1:3];
  wire          rx_done = (&pos_nxt[2:0]) && PAYLOAD_MAP[rx_slot];

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos      <= '1;
      rx_sh    <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_chan  <= '0;
    end else begin
      pos      <= pos_nxt;
      rx_sh    <= {rx_sh[6:0], ser_in};
      rx_valid <= rx_done;
      if (rx_done) begin
        rx_data <= {rx_sh[6:0], ser_in};
        rx_chan <= chan_of(rx_slot);
      end
    end
  end

  assign slot_num = pos[PW-1:3];

  // transmit side: rising edge, one bit behind the receive count
  logic [7:0] tx_sh;

  wire [2:0]    tx_bit  = pos[2:0];
  wire [SW-1:0] tx_slot = pos[PW-1:3];
  wire [SW-1:0] nx_slot = tx_slot + 1'b1;
  wire [7:0]    tx_load = PAYLOAD_MAP[tx_slot] ? tx_byte : IDLE_BYTE;
  wire          req_nxt = (&tx_bit) && PAYLOAD_MAP[nx_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_out     <= 1'b1;
      tx_sh       <= '1;
      tx_req      <= 1'b0;
      tx_req_chan <= '0;
    end else begin
      if (tx_bit == 3'd0) begin
        ser_out <= tx_load[7];
        tx_sh   <= {tx_load[6:0], 1'b0};
      end else begin
        ser_out <= tx_sh[7];
        tx_sh   <= {tx_sh[6:0], 1'b0};
      end
      tx_req <= req_nxt;
      if (req_nxt) tx_req_chan <= chan_of(nx_slot);
    end
  end

  // R4
  rx_strobe_pulse_chk: assert property (@(negedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R2
  frame_realign_chk: assert property (@(negedge clk) disable iff (!rst_n)
    frame_sync |=> (slot_num == '0));

  // R10
  slot_step_chk: assert property (@(negedge clk) disable iff (!rst_n)
    (!frame_sync && pos[2:0] == 3'd7) |=> (slot_num == SW'($past(slot_num) + 1'b1)));

  // R6
  rx_chan_range_chk: assert property (@(negedge clk) disable iff (!rst_n)
    rx_valid |-> ({1'b0, rx_chan} < (CW+1)'(PAYLOAD_CNT)));

  // R8
  tx_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> !tx_req);

endmodule

// File: tb/tdm_slot_port_tb.sv
`timescale 1ns/1ps
module tdm_slot_port_tb;
  localparam logic [7:0] IDLE = 8'h5A;

  logic clk = 1'b0, rst_n = 1'b0, frame_sync = 1'b0, ser_in = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic rx_valid, tx_req, ser_out;
  logic [7:0] rx_data;
  logic [4:0] rx_chan, tx_req_chan, slot_num;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  tdm_slot_port #(.IDLE_BYTE(IDLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .ser_in(ser_in),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_chan(rx_chan), .slot_num(slot_num),
    .tx_byte(tx_byte), .tx_req(tx_req), .tx_req_chan(tx_req_chan), .ser_out(ser_out));

  always #10 clk = ~clk;

  function automatic bit pay(input int s); return (s % 4) != 3; endfunction
  function automatic int chn(input int s); return s - s / 4; endfunction
  function automatic logic [7:0] rxb(input int s, input logic [7:0] seed);
    return seed ^ 8'(s * 29);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [7:0] seed, input logic [7:0] txseed,
                           input bit fs, input bit skip0);
    for (int k = 0; k < 256; k++) begin
      @(posedge clk); #2;
      if (k >= 1) begin
        int j = k - 1, s = (k - 1) / 8, b = (k - 1) % 8;
        logic [7:0] eb = pay(s) ? (txseed ^ 8'(chn(s))) : IDLE;
        bit er = (b == 7) && pay((s + 1) % 32);
        if (!(skip0 && j < 8))
          chk(ser_out == eb[7-b], pay(s) ? "R7 tx bit" : "R9 idle bit", ser_out, eb[7-b]);
        chk(tx_req == er, "R8 tx_req", tx_req, er);
        if (er) chk(tx_req_chan == 5'(chn((s + 1) % 32)), "R8 tx_req_chan",
                    tx_req_chan, chn((s + 1) % 32));
      end
      if (tx_req) tx_byte = txseed ^ {3'b000, tx_req_chan};
      else if (!pay(k / 8)) tx_byte = ~txseed;
      begin
        logic [7:0] rb = rxb(k / 8, seed);
        ser_in = rb[7 - k % 8];
      end
      frame_sync = fs && (k == 0);
      @(negedge clk); #5;
      begin
        int s = k / 8;
        bit ev = (k % 8 == 7) && pay(s);
        chk(slot_num == 5'(s), (fs && k == 0) ? "R2 slot after sync" : "R10 slot count",
            slot_num, s);
        chk(rx_valid == ev, pay(s) ? "R4 rx_valid" : "R5 idle no strobe", rx_valid, ev);
        if (ev) begin
          chk(rx_data == rxb(s, seed), "R3 rx_data", rx_data, rxb(s, seed));
          chk(rx_chan == 5'(chn(s)), "R6 rx_chan", rx_chan, chn(s));
        end
      end
    end
  endtask

  task automatic test_reset();
    repeat (3) @(posedge clk);
    #2;
    chk(ser_out == 1'b1, "R1 ser_out", ser_out, 1);
    chk(rx_valid == 1'b0, "R1 rx_valid", rx_valid, 0);
    chk(tx_req == 1'b0, "R1 tx_req", tx_req, 0);
    chk(slot_num == 5'd31, "R1 slot_num", slot_num, 31);
    rst_n = 1'b1;
  endtask

  task automatic test_aligned();
    run_frame(8'h3C, 8'hC3, 1'b1, 1'b1);
    run_frame(8'h96, 8'h21, 1'b0, 1'b0);  // R10 wrap without sync
  endtask

  task automatic test_patterns();
    run_frame(8'h00, 8'hFF, 1'b0, 1'b0);
    run_frame(8'hFF, 8'h00, 1'b1, 1'b0);
    run_frame(8'hA5, 8'h5A, 1'b0, 1'b0);
  endtask

  task automatic test_realign();
    for (int k = 0; k < 77; k++) begin
      @(posedge clk); #2;
      ser_in = k[0];
      frame_sync = 1'b0;
    end
    run_frame(8'h71, 8'h8E, 1'b1, 1'b1);  // R2 mid-frame sync
    run_frame(8'h1D, 8'hE2, 1'b0, 1'b0);
  endtask

  initial begin
    test_reset();
    test_aligned();
    test_patterns();
    test_realign();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule